// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

A 32-bit processor that retires one instruction per clock. It supports register add, subtract and OR, OR with an immediate, word load, word store and branch-if-equal. The core holds a 32-entry register file, an immediate extender, a three-function ALU with a zero flag, and small word-addressed instruction and data memories. Control is split into two parts. A main decoder turns the opcode into datapath strobes and a two-bit ALU class. A local decoder combines that class with the function field to pick the ALU operation.

A test environment fills both memories through a load port while reset is held, then releases reset. Progress is watched through the current PC and a write-back monitor that shows the register write made at the end of each cycle.

Top module: `rv6_core`

## Requirements
- R1: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0] and immediate [15:0]. The supported opcodes are 000000 (register class), 001101 (OR-immediate), 100011 (load), 101011 (store) and 000100 (branch-if-equal).
- R2: A register-class instruction writes rd. The function field must have bits [5:4] = 10, and its bits [2:0] select the operation: 000 is add, 010 is rs minus rt, and 101 is OR. Function bit 3 has no effect. Any other function value writes nothing.
- R3: OR-immediate writes rs OR the zero-extended immediate into rt.
- R4: Load writes into rt the data word at byte address rs plus the sign-extended immediate. That byte address, divided by 4, is the word index.
- R5: Store writes rt into the data word at rs plus the sign-extended immediate, and it writes no register.
- R6: Branch-if-equal writes nothing. When rs equals rt, the next PC is PC+4 plus the sign-extended immediate times 4; otherwise it is PC+4.
- R7: Register 0 always reads as zero. A write aimed at it is shown on the monitor but does not change it.
- R8: An unsupported opcode writes neither a register nor memory, and the PC advances by 4.
- R9: Reset is synchronous and active-high. It sets the PC to 0 and clears every register.
- R10: pcOut shows the PC of the instruction now executing. wbEn, wbAddr and wbData show the register write that this instruction makes at the next rising edge.
- R11: On a rising edge with loadEn high, loadData is written to word loadAddr of the instruction memory (loadToData = 0) or of the data memory (loadToData = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Memory load strobe |
| loadToData | input | 1 | Load target: 0 = instruction memory, 1 = data memory |
| loadAddr | input | 6 | Word index for the load |
| loadData | input | 32 | Word to load |
| pcOut | output | 32 | Current PC |
| wbEn | output | 1 | Register write this cycle |
| wbAddr | output | 5 | Register written |
| wbData | output | 32 | Value written |

## Verification
The hardest conditions to reach from the ports are two. The first is a branch that is taken backwards, so that a loop repeats until a register that is counted down reaches zero. The second is a store followed by a load from the same word, which is the only way to see the store land. The loaded program builds both: a three-pass countdown loop closed by a negative branch offset, and a store whose address comes from a register and a negative offset, read back at once by a load. A reset in the middle of the run, followed by a first instruction that adds two registers which were written during the earlier pass, shows whether the registers were cleared.

// File: rtl/rv6_pkg.sv
package rv6_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BEQ  = 6'b000100;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_OR  = 3'd2
  } aluFn_e;

  typedef enum logic [1:0] {
    CLS_ADD  = 2'd0,
    CLS_SUB  = 2'd1,
    CLS_OR   = 2'd2,
    CLS_FUNC = 2'd3
  } aluClass_e;

  typedef struct packed {
    logic   regWrite;
    logic   memWrite;
    logic   memToReg;
    logic   destRd;
    logic   useImm;
    logic   extSign;
    logic   branch;
    aluFn_e aluFn;
  } ctrl_t;
endpackage

// File: rtl/rv6_control.sv
module rv6_control
  import rv6_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] func,
  output ctrl_t      ctl
);
  aluClass_e aluClass;
  ctrl_t     mainCtl;
  logic      funcOk;
  aluFn_e    funcSel;

  // main decoder: opcode to strobes and ALU class
  always_comb begin
    mainCtl  = '0;
    aluClass = CLS_ADD;
    unique case (opcode)
      OPC_REG: begin
        mainCtl.regWrite = 1'b1;
        mainCtl.destRd   = 1'b1;
        aluClass         = CLS_FUNC;
      end
      OPC_ORI: begin
        mainCtl.regWrite = 1'b1;
        mainCtl.useImm   = 1'b1;
        aluClass         = CLS_OR;
      end
      OPC_LOAD: begin
        mainCtl.regWrite = 1'b1;
        mainCtl.useImm   = 1'b1;
        mainCtl.extSign  = 1'b1;
        mainCtl.memToReg = 1'b1;
      end
      OPC_STOR: begin
        mainCtl.memWrite = 1'b1;
        mainCtl.useImm   = 1'b1;
        mainCtl.extSign  = 1'b1;
      end
      OPC_BEQ: begin
        mainCtl.branch  = 1'b1;
        mainCtl.extSign = 1'b1;
        aluClass        = CLS_SUB;
      end
      default: ;
    endcase
  end

  // local decoder: function bits [5:4] and [2:0]; bit 3 is ignored
  always_comb begin
    funcOk  = 1'b0;
    funcSel = ALU_ADD;
    if (func[5:4] == 2'b10) begin
      unique case (func[2:0])
        3'b000:  begin funcOk = 1'b1; funcSel = ALU_ADD; end
        3'b010:  begin funcOk = 1'b1; funcSel = ALU_SUB; end
        3'b101:  begin funcOk = 1'b1; funcSel = ALU_OR;  end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl = mainCtl;
    unique case (aluClass)
      CLS_ADD:  ctl.aluFn = ALU_ADD;
      CLS_SUB:  ctl.aluFn = ALU_SUB;
      CLS_OR:   ctl.aluFn = ALU_OR;
      default: begin
        ctl.aluFn    = funcSel;
        ctl.regWrite = mainCtl.regWrite & funcOk;
      end
    endcase
  end
endmodule

// File: rtl/rv6_datapath.sv
module rv6_datapath
  import rv6_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_t                ctl,
  input  logic                 loadEn,
  input  logic                 loadToData,
  input  logic [MEM_AW-1:0]    loadAddr,
  input  logic [XLEN-1:0]      loadData,
  output logic [5:0]           opcode,
  output logic [5:0]           func,
  output logic [XLEN-1:0]      pcOut,
  output logic                 wbEn,
  output logic [REG_AW-1:0]    wbAddr,
  output logic [XLEN-1:0]      wbData
);
  localparam int MEM_WORDS = 1 << MEM_AW;
  localparam int REGS      = 1 << REG_AW;

  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];
  logic [XLEN-1:0] rf   [REGS];

  logic [XLEN-1:0]   pcQ, instr, rdA, rdB, immExt, opB, aluRes, memRd;
  logic [XLEN-1:0]   wbVal, pcPlus4, brTarget, nextPc;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, destIdx;
  logic [15:0]       imm;
  logic              aluZero, takeBr;

  assign instr  = imem[pcQ[MEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign func   = instr[5:0];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign imm    = instr[15:0];

  assign rdA    = rf[rsIdx];
  assign rdB    = rf[rtIdx];
  assign immExt = ctl.extSign ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  assign opB    = ctl.useImm ? immExt : rdB;

  always_comb begin
    unique case (ctl.aluFn)
      ALU_SUB: aluRes = rdA - opB;
      ALU_OR:  aluRes = rdA | opB;
      default: aluRes = rdA + opB;
    endcase
  end
  assign aluZero = (aluRes == '0);

  assign memRd   = dmem[aluRes[MEM_AW+1:2]];
  assign wbVal   = ctl.memToReg ? memRd : aluRes;
  assign destIdx = ctl.destRd ? rdIdx : rtIdx;

  assign pcPlus4  = pcQ + XLEN'(4);
  assign brTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign takeBr   = ctl.branch & aluZero;
  assign nextPc   = takeBr ? brTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pcQ <= '0;
    else     pcQ <= nextPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) rf[i] <= '0;
    end else if (ctl.regWrite && destIdx != '0) begin
      rf[destIdx] <= wbVal;
    end
  end

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr] <= loadData;
  end

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)       dmem[loadAddr] <= loadData;
    else if (ctl.memWrite && !rst)  dmem[aluRes[MEM_AW+1:2]] <= rdB;
  end

  assign pcOut  = pcQ;
  assign wbEn   = ctl.regWrite;
  assign wbAddr = destIdx;
  assign wbData = wbVal;

  AST_R0_STAYS_ZERO: assert property (@(posedge clk) disable iff (rst)
    rf[0] == '0);                                                   // R7
  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (rst)
    ctl.memWrite |-> !ctl.regWrite);                                // R5
  AST_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    (ctl.useImm && !ctl.extSign) |-> opB[XLEN-1:16] == '0);          // R3
  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !ctl.branch |=> pcQ == $past(pcQ) + XLEN'(4));                   // R8
  AST_BRANCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && rdA == rdB) |=> pcQ == $past(pcQ + XLEN'(4) + {immExt[XLEN-3:0], 2'b00})); // R6
endmodule

// File: rtl/rv6_core.sv
module rv6_core
  import rv6_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic              loadToData,
  input  logic [MEM_AW-1:0] loadAddr,
  input  logic [31:0]       loadData,
  output logic [31:0]       pcOut,
  output logic              wbEn,
  output logic [4:0]        wbAddr,
  output logic [31:0]       wbData
);
  ctrl_t      ctl;
  logic [5:0] opcode, func;

  rv6_control u_ctrl (
    .opcode (opcode),
    .func   (func),
    .ctl    (ctl)
  );

  rv6_datapath #(.MEM_AW(MEM_AW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .opcode     (opcode),
    .func       (func),
    .pcOut      (pcOut),
    .wbEn       (wbEn),
    .wbAddr     (wbAddr),
    .wbData     (wbData)
  );
endmodule

// File: tb/tb_rv6_core.sv
module tb_rv6_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadEn = 1'b0, loadToData = 1'b0;
  logic [5:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [31:0] pcOut, wbData;
  logic        wbEn;
  logic [4:0]  wbAddr;

  always #2 clk = ~clk;   // 250 MHz

  rv6_core dut (.*);

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0, afterReset = 0;

  logic [31:0] mImem [64];
  logic [31:0] mDmem [64];
  logic [31:0] mReg  [32];
  logic [31:0] mPc;

  // model results for the current instruction
  logic        eWe, eMw, eBr, eKnown;
  logic [4:0]  eDst;
  logic [31:0] eData, eNext, eMAddr, eMData;
  string       eTag;

  function automatic logic [31:0] rIns(int rs, int rt, int rd, int fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] iIns(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (pc=%h)", tag, act, exp, mPc);
    end
  endtask

  task automatic evalModel();
    logic [31:0] ins, a, b, sx, zx;
    logic [5:0] op, fn;
    ins = mImem[mPc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    a = mReg[ins[25:21]]; b = mReg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]}; zx = {16'd0, ins[15:0]};
    eWe = 0; eMw = 0; eBr = 0; eKnown = 1; eDst = 0; eData = 0;
    eNext = mPc + 4; eMAddr = 0; eMData = 0; eTag = "R8";
    if (op == 6'b000000) begin
      eTag = "R1 R2"; eDst = ins[15:11];
      if (fn[5:4] == 2'b10 && fn[2:0] == 3'b000) begin eWe = 1; eData = a + b; end
      else if (fn[5:4] == 2'b10 && fn[2:0] == 3'b010) begin eWe = 1; eData = a - b; end
      else if (fn[5:4] == 2'b10 && fn[2:0] == 3'b101) begin eWe = 1; eData = a | b; end
    end else if (op == 6'b001101) begin
      eTag = "R3"; eWe = 1; eDst = ins[20:16]; eData = a | zx;
    end else if (op == 6'b100011) begin
      eTag = "R4 R11"; eWe = 1; eDst = ins[20:16]; eData = mDmem[(a + sx) >> 2];
    end else if (op == 6'b101011) begin
      eTag = "R5"; eMw = 1; eMAddr = (a + sx) >> 2; eMData = b;
    end else if (op == 6'b000100) begin
      eTag = "R6"; eBr = (a == b);
      if (eBr) eNext = mPc + 4 + (sx << 2);
    end else eKnown = 0;
    if (eWe && eDst == 0) eTag = "R7";
    if (mPc == 0 && afterReset) eTag = "R9";
  endtask

  task automatic commitModel();
    if (eWe && eDst != 0) mReg[eDst] = eData;
    if (eMw) mDmem[eMAddr[5:0]] = eMData;
    mPc = eNext;
  endtask

  task automatic resetModel();
    for (int i = 0; i < 32; i++) mReg[i] = '0;
    mPc = '0;
  endtask

  task automatic runCycles(int n, bit rstNext);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evalModel();
      check(pcOut === mPc, (mPc == 0) ? "R9 R10" : "R10", pcOut, mPc);
      if (!rst) begin
        check(wbEn === eWe, eTag, {31'd0, wbEn}, {31'd0, eWe});
        if (eWe) begin
          check(wbAddr === eDst, eTag, {27'd0, wbAddr}, {27'd0, eDst});
          check(wbData === eData, eTag, wbData, eData);
        end
      end
      rst = rstNext;
      if (rstNext) begin resetModel(); afterReset = 1; end
      else if (!rst) commitModel();
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mImem[i] = '0;
      mDmem[i] = 32'h0000_2468 + 32'h1357_9bdf * i;
    end
    mImem[0]  = rIns(15, 1, 20, 6'h20);        // R9: reads registers the first pass wrote
    mImem[1]  = iIns(6'b001101, 0, 1, 16'h8005);
    mImem[2]  = iIns(6'b001101, 0, 4, 12);
    mImem[3]  = iIns(6'b100011, 0, 2, 4);
    mImem[4]  = iIns(6'b100011, 4, 3, -4);
    mImem[5]  = rIns(2, 3, 5, 6'h20);
    mImem[6]  = rIns(2, 3, 6, 6'h22);
    mImem[7]  = iIns(6'b101011, 4, 5, 16);
    mImem[8]  = iIns(6'b100011, 0, 7, 28);
    mImem[9]  = rIns(5, 5, 0, 6'h20);          // R7
    mImem[10] = rIns(0, 0, 8, 6'h20);
    mImem[11] = iIns(6'b000100, 7, 5, 1);
    mImem[12] = iIns(6'b001101, 0, 9, 16'hdead);
    mImem[13] = iIns(6'b000100, 2, 3, 5);
    mImem[14] = rIns(2, 3, 10, 6'h28);         // R2 bit 3 ignored
    mImem[15] = rIns(2, 3, 11, 6'h25);
    mImem[16] = 32'hffff_ffff;                 // R8
    mImem[17] = rIns(2, 3, 12, 6'h21);         // R2 unsupported function
    mImem[18] = iIns(6'b001101, 0, 14, 1);
    mImem[19] = iIns(6'b001101, 0, 13, 3);
    mImem[20] = rIns(13, 14, 13, 6'h22);
    mImem[21] = iIns(6'b000100, 13, 0, 1);
    mImem[22] = iIns(6'b000100, 0, 0, -3);
    mImem[23] = iIns(6'b101011, 4, 1, -8);
    mImem[24] = iIns(6'b100011, 0, 15, 4);
    mImem[25] = iIns(6'b000100, 0, 0, -1);
    for (int i = 0; i < 64; i++) begin        // R11 load port
      @(negedge clk); loadEn = 1; loadToData = 0; loadAddr = 6'(i); loadData = mImem[i];
      @(negedge clk); loadToData = 1; loadData = mDmem[i];
    end
    @(negedge clk); loadEn = 0;
    resetModel();
    runCycles(1, 0);
    runCycles(70, 0);
    runCycles(1, 1);                           // R9 mid-run reset
    runCycles(1, 0);
    runCycles(70, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule